// File: doc/BRIEF.md
# Oversampled Serial Receive Data Recovery

This block is the data-recovery front end of an asynchronous serial receiver. The receive line goes through a short synchronizer. It is then sampled once per pulse of a receive-time enable, which runs at OSR (default 16) pulses per bit period. While the line is idle, the block looks for a falling edge. It accepts that edge only after the line has been steadily high. It then checks the start bit a few times early in the bit period before committing to a frame.

Each data bit is decided by a two-of-three vote over the samples nearest the middle of the bit. The block flags noise whenever the samples it looks at disagree. At the stop position it reports a framing error if the line is low there, and a break is reported the same way. A finished frame appears on a parallel output together with a one-period ready strobe. The data and both flags stay unchanged until the next frame finishes.

Top module: `uart_rx_recover`

## Requirements
- R1: After reset, rx_ready, noise_flag and frame_err are 0 and rx_data is all zeros. The synchronizer and the edge history treat the line as high.
- R2: A frame begins only on a low sample that directly follows three consecutive high samples. A low sample after fewer than three highs starts nothing, so that frame produces no ready strobe.
- R3: The start bit is checked at counts 3, 5 and 7 of its period, where count 1 is the qualifying low sample. If two or more of these samples are high, the frame is dropped without a strobe and the edge search resumes.
- R4: If exactly one of the start check samples is high, the frame is still received and its noise_flag is 1.
- R5: Each data bit is the majority of its samples at counts 8, 9 and 10, and the bits arrive least significant first. After the last data bit follows one stop bit.
- R6: If the three mid-bit samples of any data or stop bit disagree, noise_flag is 1 for that frame. The bit timing is not restarted, so the frame completes on its normal schedule.
- R7: The count 8, 9 and 10 samples of the start bit have no effect on the data or on noise_flag.
- R8: frame_err is 1 when the stop bit votes low. This includes a break, where every bit is low.
- R9: rx_ready is high for exactly one enable period per frame. It rises on the enable pulse that takes count 10 of the stop bit. rx_data, noise_flag and frame_err take their new values on that same pulse.
- R10: rx_data, noise_flag and frame_err hold their values between frames. Each is cleared or set again only when the next frame completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_en | input | 1 | Receive-time enable, OSR pulses per bit period |
| rxd_in | input | 1 | Raw asynchronous serial receive line |
| rx_data | output | DATA_BITS | Last received data word |
| rx_ready | output | 1 | One-period strobe marking a completed frame |
| noise_flag | output | 1 | Sample disagreement seen in the last frame |
| frame_err | output | 1 | Stop bit of the last frame sampled low |

## Verification
The bench drives one line value per enable period. The synchronizer delays every value by exactly one period, so a start bit driven in period T becomes count 1 in period T+1. The ready strobe, data and flags are therefore due in period T+154 (nine full bit periods plus ten counts). The bench checks the strobe in that exact period and requires that it is the only strobe of the run. Rejected and unqualified starts are judged by the absence of any strobe across the whole stimulus plus idle time. Flag hold is read during the idle stretch just before the next frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [0:0] {
      RX_HUNT = 1'b0,
      RX_BITS = 1'b1
   } rx_state_e;

   function automatic logic vote3(input logic [2:0] s);
      return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
   endfunction

   function automatic logic split3(input logic [2:0] s);
      return (|s) & ~(&s);
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RESET_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_edge_qual.sv
module uart_rx_edge_qual #(
   parameter int RUN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic samp,
   output logic edge_ok
);
   generate
      if (RUN < 2) begin : g_bad_run
         $error("uart_rx_edge_qual: RUN must be at least 2");
      end
   endgenerate

   logic [RUN-1:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist <= '1;
      else if (tick) hist <= {hist[RUN-2:0], samp};
   end

   assign edge_ok = tick & ~samp & (&hist);
endmodule

// File: rtl/uart_rx_window.sv
module uart_rx_window #(
   parameter int PW    = 5,
   parameter int FIRST = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          samp,
   input  logic [PW-1:0] ph,
   output logic [2:0]    trio
);
   logic [1:0] held;
   logic       in_win;

   assign in_win = (ph == PW'(FIRST)) || (ph == PW'(FIRST + 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              held <= '0;
      else if (tick && in_win) held <= {held[0], samp};
   end

   assign trio = {held, samp};
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rt_en,
   input  logic                 rxd_in,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_ready,
   output logic                 noise_flag,
   output logic                 frame_err
);
   localparam int PW       = $clog2(OSR + 1);
   localparam int IW       = $clog2(DATA_BITS + 2);
   localparam int MID      = OSR / 2;
   localparam int V1       = MID - 5;
   localparam int V2       = MID - 3;
   localparam int V3       = MID - 1;
   localparam int S1       = MID;
   localparam int S3       = MID + 2;
   localparam int STOP_IDX = DATA_BITS + 1;

   generate
      if (OSR < 14 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_rx_recover: OSR must be even and at least 14");
      end
      if (DATA_BITS < 1) begin : g_bad_bits
         $error("uart_rx_recover: DATA_BITS must be at least 1");
      end
   endgenerate

   logic                 samp;
   logic                 edge_ok;
   logic [2:0]           trio;
   logic                 vote_bit;
   logic                 disagree;
   rx_state_e            state;
   logic [PW-1:0]        ph;
   logic [IW-1:0]        idx;
   logic [1:0]           ver_hi;
   logic [1:0]           ver_total;
   logic                 noise_acc;
   logic [DATA_BITS-1:0] shreg;
   logic [DATA_BITS-1:0] shreg_next;

   uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd_in), .q(samp)
   );

   uart_rx_edge_qual #(.RUN(3)) u_edge (
      .clk(clk), .rst_n(rst_n), .tick(rt_en), .samp(samp), .edge_ok(edge_ok)
   );

   uart_rx_window #(.PW(PW), .FIRST(S1)) u_win (
      .clk(clk), .rst_n(rst_n), .tick(rt_en), .samp(samp), .ph(ph), .trio(trio)
   );

   assign vote_bit  = vote3(trio);
   assign disagree  = split3(trio);
   assign ver_total = ver_hi + {1'b0, samp};

   generate
      if (DATA_BITS == 1) begin : g_sh1
         assign shreg_next = vote_bit;
      end else begin : g_shn
         assign shreg_next = {vote_bit, shreg[DATA_BITS-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_HUNT;
         ph         <= '0;
         idx        <= '0;
         ver_hi     <= '0;
         noise_acc  <= 1'b0;
         shreg      <= '0;
         rx_data    <= '0;
         rx_ready   <= 1'b0;
         noise_flag <= 1'b0;
         frame_err  <= 1'b0;
      end else if (rt_en) begin
         rx_ready <= 1'b0;
         case (state)
            RX_HUNT: begin
               if (edge_ok) begin
                  state     <= RX_BITS;
                  ph        <= PW'(2);
                  idx       <= '0;
                  ver_hi    <= '0;
                  noise_acc <= 1'b0;
               end
            end
            RX_BITS: begin
               if (ph == PW'(OSR)) begin
                  ph  <= PW'(1);
                  idx <= idx + 1'b1;
               end else begin
                  ph <= ph + 1'b1;
               end
               if (idx == '0) begin
                  if (ph == PW'(V1) || ph == PW'(V2)) ver_hi <= ver_total;
                  if (ph == PW'(V3)) begin
                     if (ver_total >= 2'd2)      state     <= RX_HUNT;
                     else if (ver_total == 2'd1) noise_acc <= 1'b1;
                  end
               end else if (ph == PW'(S3)) begin
                  if (idx == IW'(STOP_IDX)) begin
                     rx_data    <= shreg;
                     frame_err  <= ~vote_bit;
                     noise_flag <= noise_acc | disagree;
                     rx_ready   <= 1'b1;
                     state      <= RX_HUNT;
                  end else begin
                     shreg <= shreg_next;
                     if (disagree) noise_acc <= 1'b1;
                  end
               end
            end
            default: state <= RX_HUNT;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_recover_chk.sv
module uart_rx_recover_chk #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rt_en,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 rx_ready,
   input logic                 noise_flag,
   input logic                 frame_err
);
   // R9: the strobe only moves on an enable pulse
   p_ready_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_ready) |-> $past(rt_en));

   // R9: the strobe lasts one enable period
   p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && rt_en) |=> !rx_ready);

   // R10: the framing flag changes only as a frame completes
   p_fe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_err) |-> rx_ready);

   // R6: the noise flag changes only as a frame completes
   p_noise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(noise_flag) |-> rx_ready);

   // R5: the data word changes only as a frame completes
   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> rx_ready);
endmodule

bind uart_rx_recover uart_rx_recover_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .rt_en(rt_en), .rx_data(rx_data),
   .rx_ready(rx_ready), .noise_flag(noise_flag), .frame_err(frame_err)
);

// File: tb/uart_rx_recover_test.sv
`timescale 1ns/1ps
module uart_rx_recover_test;
   localparam int DB  = 8;
   localparam int OSR = 16;
   localparam int LAT = (DB + 1) * OSR + 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rt_en = 1'b0;
   logic          rxd = 1'b1;
   logic [DB-1:0] rx_data;
   logic          rx_ready, noise_flag, frame_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic          samp [0:511];
   int            nsamp;
   int            rdy_cnt, rdy_at;
   logic [DB-1:0] got_d;
   logic          got_n, got_f;

   uart_rx_recover #(.DATA_BITS(DB), .OSR(OSR), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .rt_en(rt_en), .rxd_in(rxd),
      .rx_data(rx_data), .rx_ready(rx_ready),
      .noise_flag(noise_flag), .frame_err(frame_err)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         errors++;
         $display("FAIL R9 watchdog expired actual=%0d expected=<190000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic v);
      @(negedge clk) begin rxd = v; rt_en = 1'b1; end
      @(negedge clk) rt_en = 1'b0;
   endtask

   task automatic fill(input int from, input int to, input logic v);
      for (int i = from; i <= to; i++) samp[i] = v;
   endtask

   task automatic build(input int off, input logic [DB-1:0] d, input logic stopv);
      for (int b = 0; b < DB + 2; b++) begin
         logic v;
         v = (b == 0) ? 1'b0 : (b == DB + 1) ? stopv : d[b-1];
         for (int r = 0; r < OSR; r++) samp[off + b*OSR + r] = v;
      end
      nsamp = off + (DB + 2) * OSR;
   endtask

   task automatic play(input int idle);
      rdy_cnt = 0;
      rdy_at  = -1;
      for (int i = 0; i < nsamp + idle; i++) begin
         tick((i < nsamp) ? samp[i] : 1'b1);
         if (rx_ready) begin
            rdy_cnt++;
            if (rdy_at < 0) begin
               rdy_at = i;
               got_d  = rx_data;
               got_n  = noise_flag;
               got_f  = frame_err;
            end
         end
      end
   endtask

   task automatic expect_frame(input string req, input int off, input logic [DB-1:0] d,
                               input logic n, input logic f);
      check(rdy_cnt == 1, "R9", "strobe count", rdy_cnt, 1);
      check(rdy_at == off + LAT, "R9", "strobe period", rdy_at, off + LAT);
      check(got_d == d, req, "data", got_d, d);
      check(got_n == n, req, "noise", got_n, n);
      check(got_f == f, req, "frame error", got_f, f);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(rx_ready == 1'b0, "R1", "reset ready", rx_ready, 0);
      check(noise_flag == 1'b0, "R1", "reset noise", noise_flag, 0);
      check(frame_err == 1'b0, "R1", "reset frame error", frame_err, 0);
      check(rx_data == '0, "R1", "reset data", rx_data, 0);
      rst_n = 1'b1;
      repeat (10) tick(1'b1);

      // R2 R5: every byte, clean line, qualified edge after idle
      for (int d = 0; d < 256; d++) begin
         build(0, DB'(d), 1'b1);
         play(20);
         expect_frame("R5", 0, DB'(d), 1'b0, 1'b0);
      end

      // R6: one sample of bit 3 flipped, vote unaffected, timing unchanged
      build(0, 8'hA5, 1'b1);
      samp[4*OSR + 8] = ~samp[4*OSR + 8];
      play(20);
      expect_frame("R6", 0, 8'hA5, 1'b1, 1'b0);
      check(noise_flag == 1'b1, "R10", "noise held in idle", noise_flag, 1);

      // R10: next clean frame clears noise
      build(0, 8'h3C, 1'b1);
      play(20);
      expect_frame("R10", 0, 8'h3C, 1'b0, 1'b0);

      // R5: two of three samples of bit 5 flipped, majority follows
      build(0, 8'h0F, 1'b1);
      samp[6*OSR + 7] = ~samp[6*OSR + 7];
      samp[6*OSR + 9] = ~samp[6*OSR + 9];
      play(20);
      expect_frame("R5", 0, 8'h2F, 1'b1, 1'b0);

      // R8: stop bit low
      build(0, 8'h81, 1'b0);
      play(20);
      expect_frame("R8", 0, 8'h81, 1'b0, 1'b1);
      check(frame_err == 1'b1, "R10", "frame error held in idle", frame_err, 1);
      build(0, 8'h42, 1'b1);
      play(20);
      expect_frame("R10", 0, 8'h42, 1'b0, 1'b0);

      // R8: break, line stays low afterwards
      build(0, 8'h00, 1'b0);
      fill(nsamp, nsamp + 19, 1'b0);
      nsamp = nsamp + 20;
      play(0);
      expect_frame("R8", 0, 8'h00, 1'b0, 1'b1);

      // R2: only two highs before the next low, no frame
      fill(0, 1, 1'b1);
      build(2, 8'h00, 1'b1);
      play(20);
      check(rdy_cnt == 0, "R2", "unqualified edge strobes", rdy_cnt, 0);

      // R3: short low glitch rejected, later frame received
      fill(0, 1, 1'b0);
      fill(2, 39, 1'b1);
      build(40, 8'h5A, 1'b1);
      play(20);
      expect_frame("R3", 40, 8'h5A, 1'b0, 1'b0);

      // R3: counts 3 and 7 high rejects start
      fill(0, 1, 1'b0);
      samp[2] = 1'b1;
      fill(3, 5, 1'b0);
      fill(6, 39, 1'b1);
      build(40, 8'hC3, 1'b1);
      play(20);
      expect_frame("R3", 40, 8'hC3, 1'b0, 1'b0);

      // R4: only count 5 high, accepted with noise
      build(0, 8'h96, 1'b1);
      samp[4] = 1'b1;
      play(20);
      expect_frame("R4", 0, 8'h96, 1'b1, 1'b0);

      // R7: start bit counts 8..10 high are ignored
      build(0, 8'h69, 1'b1);
      fill(7, 9, 1'b1);
      play(20);
      expect_frame("R7", 0, 8'h69, 1'b0, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule